// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single atomic-access reservation of a load/store unit. A reserve-load claims the aligned 32-byte granule that holds its address. A later conditional store succeeds only while that claim is still held. The claim ends when any conditional store completes, when a newer reserve-load replaces it, or when another bus master is seen storing into the same granule.

Requests arrive on one port, one per cycle. A type bit tells a reserve-load from a conditional store. Each request carries:
- the effective address;
- the 4-bit page attribute field;
- the data-cache-locked flag;
- the record bit;
- the summary-overflow copy used in the condition field.

Each request is checked for faults. The first cause found, in a fixed priority order, is reported, and a faulting request does not touch the reservation. A request that does not fault yields a pass/fail result and, where the form asks for one, a condition-field write. Invalid record-bit forms are marked undefined. All results appear on registered outputs one cycle after the request.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `rsv_valid_o`, `done_o`, `sc_pass_o`, `cr_wr_o`, `cr_undef_o` are 0, and `exc_o` and `cr_o` are all zeros.
- R2: A reserve-load that does not fault sets `rsv_valid_o` in the next cycle and records granule `addr >> GRANULE_LG`. It replaces any earlier reservation.
- R3: A conditional store that does not fault passes (`sc_pass_o`=1 one cycle later) only if a reservation is valid and the store's address lies in the same granule. Address bits below `GRANULE_LG` are ignored. Any difference in higher bits fails the store.
- R4: A conditional store that does not fault clears the reservation, whether it passes or fails.
- R5: A snooped store whose address lies in the reserved granule clears the reservation, and a snooped store to any other granule leaves it in place. If the snoop hits in the same cycle as a conditional store, the store fails. If it hits in the same cycle as a reserve-load, the new reservation is taken.
- R6: A request whose `addr[1:0]` is nonzero reports `exc_o`=2'd1 (alignment). This cause wins over every other.
- R7: An aligned request on a page whose attributes match 10xx (`wimg[3]`=1, `wimg[2]`=0) reports `exc_o`=2'd2 (storage fault, write-through). This cause wins over the cache lock.
- R8: An aligned request on a page that is not write-through, while the data cache is locked, reports `exc_o`=2'd3 (storage fault, locked cache).
- R9: A faulting request leaves the reservation unchanged. It gives `sc_pass_o`=0, `cr_wr_o`=0 and `cr_undef_o`=0, and `done_o` is still 1.
- R10: A conditional store with the record bit set writes the condition field with `cr_undef_o`=0. The field is `cr_o` = {LT, GT, EQ, SO} with bit 3 = LT = 0, bit 2 = GT = 0, bit 1 = EQ = pass, and bit 0 = SO = `xer_so_i`.
- R11: A conditional store with the record bit clear still sets `cr_wr_o`, with `cr_undef_o`=1 and the same `cr_o` encoding. Its pass/fail outcome and its clearing of the reservation are unchanged.
- R12: A reserve-load with the record bit set gives `cr_wr_o`=1, `cr_undef_o`=1 and `cr_o`=0, and takes the reservation as usual. With the record bit clear it writes no condition field.
- R13: In a cycle after no request, `done_o`, `sc_pass_o`, `cr_wr_o` and `cr_undef_o` are 0, and `exc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_is_sc_i | input | 1 | 1 = conditional store, 0 = reserve-load |
| req_addr_i | input | ADDR_W | Effective address |
| req_wimg_i | input | 4 | Page attribute field; 10xx marks write-through |
| req_dc_locked_i | input | 1 | Data cache is locked |
| req_rc_i | input | 1 | Record bit of the instruction |
| xer_so_i | input | 1 | Summary-overflow copy for the condition field |
| snp_valid_i | input | 1 | Store by another master observed |
| snp_addr_i | input | ADDR_W | Address of the snooped store |
| rsv_valid_o | output | 1 | Reservation held |
| done_o | output | 1 | Result of last cycle's request is on the outputs |
| sc_pass_o | output | 1 | Conditional store succeeded |
| exc_o | output | 2 | 0 none, 1 alignment, 2 storage write-through, 3 storage locked cache |
| cr_wr_o | output | 1 | Condition field is written |
| cr_undef_o | output | 1 | Written condition field is undefined |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench builds the block with `ADDR_W`=12 and `GRANULE_LG`=5. With a 12-bit address, a granule that differs only in the top address bit can be reached directly. The bench uses this to show that the comparison covers every bit above the granule offset, and that the offset bits within the 32-byte block are ignored. The narrow address also lets a handful of addresses cover the boundaries of adjacent granules for both the conditional stores and the snoops.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ALIGN   = 2'd1,
    EXC_DSI_WT  = 2'd2,
    EXC_DSI_LCK = 2'd3
  } exc_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;
endpackage

// File: rtl/rsv_fault_check.sv
module rsv_fault_check
  import rsv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        wimg_i,
  input  logic              dc_locked_i,
  output exc_e              exc_o
);
  logic misaligned, write_thru;

  assign misaligned = |addr_i[1:0];
  assign write_thru = wimg_i[3] & ~wimg_i[2];

  // fixed priority: alignment, attribute, lock
  always_comb begin
    if (misaligned)       exc_o = EXC_ALIGN;
    else if (write_thru)  exc_o = EXC_DSI_WT;
    else if (dc_locked_i) exc_o = EXC_DSI_LCK;
    else                  exc_o = EXC_NONE;
  end
endmodule

// File: rtl/rsv_granule_reg.sv
module rsv_granule_reg #(
  parameter int TAG_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             snp_valid_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             hit_o,
  output logic             valid_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic             kill;

  assign kill    = snp_valid_i & valid_q & (snp_tag_i == tag_q);
  // snoop in the same cycle wins over a conditional store
  assign hit_o   = valid_q & (tag_i == tag_q) & ~kill;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
    end else if (clr_i || kill) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_cr_gen.sv
module rsv_cr_gen
  import rsv_pkg::*;
(
  input  logic active_i,
  input  logic is_sc_i,
  input  logic rc_i,
  input  logic pass_i,
  input  logic so_i,
  output logic wr_o,
  output logic undef_o,
  output crf_t cr_o
);
  always_comb begin
    cr_o    = '0;
    wr_o    = 1'b0;
    undef_o = 1'b0;
    if (active_i) begin
      if (is_sc_i) begin
        wr_o    = 1'b1;
        undef_o = ~rc_i;
        cr_o.eq = pass_i;
        cr_o.so = so_i;
      end else if (rc_i) begin
        wr_o    = 1'b1;
        undef_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRANULE_LG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_is_sc_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_wimg_i,
  input  logic              req_dc_locked_i,
  input  logic              req_rc_i,
  input  logic              xer_so_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              rsv_valid_o,
  output logic              done_o,
  output logic              sc_pass_o,
  output logic [1:0]        exc_o,
  output logic              cr_wr_o,
  output logic              cr_undef_o,
  output logic [3:0]        cr_o
);
  localparam int TAG_W = ADDR_W - GRANULE_LG;

  exc_e             exc_d;
  logic             fault, active, hit, pass_d;
  logic             cr_wr_d, cr_undef_d;
  crf_t             cr_d;
  logic [TAG_W-1:0] req_tag, snp_tag;

  assign req_tag = req_addr_i[ADDR_W-1:GRANULE_LG];
  assign snp_tag = snp_addr_i[ADDR_W-1:GRANULE_LG];

  rsv_fault_check #(.ADDR_W(ADDR_W)) u_fault (
    .addr_i      (req_addr_i),
    .wimg_i      (req_wimg_i),
    .dc_locked_i (req_dc_locked_i),
    .exc_o       (exc_d)
  );

  assign fault  = (exc_d != EXC_NONE);
  assign active = req_valid_i & ~fault;

  rsv_granule_reg #(.TAG_W(TAG_W)) u_granule (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (active & ~req_is_sc_i),
    .clr_i       (active & req_is_sc_i),
    .tag_i       (req_tag),
    .snp_valid_i (snp_valid_i),
    .snp_tag_i   (snp_tag),
    .hit_o       (hit),
    .valid_o     (rsv_valid_o)
  );

  assign pass_d = active & req_is_sc_i & hit;

  rsv_cr_gen u_cr (
    .active_i (active),
    .is_sc_i  (req_is_sc_i),
    .rc_i     (req_rc_i),
    .pass_i   (pass_d),
    .so_i     (xer_so_i),
    .wr_o     (cr_wr_d),
    .undef_o  (cr_undef_d),
    .cr_o     (cr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      sc_pass_o  <= 1'b0;
      exc_o      <= EXC_NONE;
      cr_wr_o    <= 1'b0;
      cr_undef_o <= 1'b0;
      cr_o       <= '0;
    end else begin
      done_o     <= req_valid_i;
      sc_pass_o  <= pass_d;
      exc_o      <= req_valid_i ? exc_d : EXC_NONE;
      cr_wr_o    <= cr_wr_d;
      cr_undef_o <= cr_undef_d;
      cr_o       <= cr_d;
    end
  end
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_is_sc_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [3:0]        req_wimg_i,
  input logic              req_dc_locked_i,
  input logic              snp_valid_i,
  input logic              rsv_valid_o,
  input logic              done_o,
  input logic              sc_pass_o,
  input logic [1:0]        exc_o,
  input logic              cr_wr_o,
  input logic              cr_undef_o,
  input logic [3:0]        cr_o
);
  logic clean_req;
  assign clean_req = req_valid_i && (req_addr_i[1:0] == 2'b00) &&
                     !(req_wimg_i[3] && !req_wimg_i[2]) && !req_dc_locked_i;

  AST_RL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clean_req && !req_is_sc_i) |-> rsv_valid_o); // R2

  AST_PASS_NEEDS_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_pass_o |-> $past(rsv_valid_o)); // R3

  AST_SC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clean_req && req_is_sc_i) |-> !rsv_valid_o); // R4

  AST_ALIGN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && (req_addr_i[1:0] != 2'b00)) |-> exc_o == 2'd1); // R6

  AST_FAULT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o != 2'd0 && !$past(snp_valid_i)) |->
      (rsv_valid_o == $past(rsv_valid_o) && !cr_wr_o && !sc_pass_o)); // R9

  AST_CR_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_wr_o |-> cr_o[3:2] == 2'b00); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!sc_pass_o && !cr_wr_o && !cr_undef_o && exc_o == 2'd0)); // R13
endmodule

bind rsv_monitor rsv_monitor_chk #(.ADDR_W(ADDR_W)) i_rsv_monitor_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_is_sc_i     (req_is_sc_i),
  .req_addr_i      (req_addr_i),
  .req_wimg_i      (req_wimg_i),
  .req_dc_locked_i (req_dc_locked_i),
  .snp_valid_i     (snp_valid_i),
  .rsv_valid_o     (rsv_valid_o),
  .done_o          (done_o),
  .sc_pass_o       (sc_pass_o),
  .exc_o           (exc_o),
  .cr_wr_o         (cr_wr_o),
  .cr_undef_o      (cr_undef_o),
  .cr_o            (cr_o)
);

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;
  localparam int AW = 12;
  localparam int GL = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_is_sc_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [3:0]    req_wimg_i = '0;
  logic          req_dc_locked_i = 1'b0, req_rc_i = 1'b0, xer_so_i = 1'b0;
  logic          snp_valid_i = 1'b0;
  logic [AW-1:0] snp_addr_i = '0;
  logic          rsv_valid_o, done_o, sc_pass_o, cr_wr_o, cr_undef_o;
  logic [1:0]    exc_o;
  logic [3:0]    cr_o;

  always #2 clk = ~clk;

  rsv_monitor #(.ADDR_W(AW), .GRANULE_LG(GL)) i_rsv_monitor (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_is_sc_i(req_is_sc_i), .req_addr_i(req_addr_i),
    .req_wimg_i(req_wimg_i), .req_dc_locked_i(req_dc_locked_i), .req_rc_i(req_rc_i),
    .xer_so_i(xer_so_i), .snp_valid_i(snp_valid_i), .snp_addr_i(snp_addr_i),
    .rsv_valid_o(rsv_valid_o), .done_o(done_o), .sc_pass_o(sc_pass_o), .exc_o(exc_o),
    .cr_wr_o(cr_wr_o), .cr_undef_o(cr_undef_o), .cr_o(cr_o)
  );

  typedef struct {
    logic [10:0] v;   // {rsv, done, pass, exc[1:0], crw, undef, cr[3:0]}
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, failures = 0;
  logic m_valid = 1'b0;
  logic [AW-GL-1:0] m_gran = '0;

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one request cycle; expected values follow the requirements
  task automatic step(input bit v, input bit sc, input logic [AW-1:0] a,
                      input logic [3:0] w, input bit lk, input bit rc, input bit so,
                      input bit sv, input logic [AW-1:0] sa, input string tag);
    exp_t e;
    logic [1:0] ex;
    logic kill, pass, crw, und;
    logic [3:0] cr;
    @(negedge clk);
    req_valid_i = v; req_is_sc_i = sc; req_addr_i = a; req_wimg_i = w;
    req_dc_locked_i = lk; req_rc_i = rc; xer_so_i = so;
    snp_valid_i = sv; snp_addr_i = sa;
    if (a[1:0] != 0)          ex = 2'd1;
    else if (w[3:2] == 2'b10) ex = 2'd2;
    else if (lk)              ex = 2'd3;
    else                      ex = 2'd0;
    if (!v) ex = 2'd0;
    kill = sv && m_valid && (sa[AW-1:GL] == m_gran);
    pass = v && sc && ex == 0 && m_valid && (a[AW-1:GL] == m_gran) && !kill;
    crw  = v && ex == 0 && (sc || rc);
    und  = v && ex == 0 && (sc ? !rc : rc);
    cr   = (v && ex == 0 && sc) ? {2'b00, pass, so} : 4'b0;
    if (v && ex == 0 && !sc) begin
      m_valid = 1'b1; m_gran = a[AW-1:GL];
    end else if ((v && ex == 0 && sc) || kill) m_valid = 1'b0;
    e.v   = {m_valid, v, pass, ex, crw, und, cr};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  // monitor: compare one cycle's outputs against the queue head
  always @(posedge clk) begin
    exp_t e;
    logic [10:0] act;
    #1;
    if (rst_ni && q.size() > 0) begin
      e   = q.pop_front();
      act = {rsv_valid_o, done_o, sc_pass_o, exc_o, cr_wr_o, cr_undef_o, cr_o};
      checks++;
      if (act !== e.v) begin
        failures++;
        $display("FAIL %s: act=%b exp=%b", e.tag, act, e.v);
      end
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: act=running exp=done");
    finish_tb();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({rsv_valid_o, done_o, sc_pass_o, exc_o, cr_wr_o, cr_undef_o, cr_o} !== 11'b0) begin
      failures++;
      $display("FAIL R1 in reset: act=%b exp=0", {rsv_valid_o, done_o, sc_pass_o, exc_o, cr_o});
    end
    @(negedge clk); rst_ni = 1'b1;
    idle("R1 after reset");
    // R2 / R3 / R4 / R10
    step(1, 0, 12'h040, 4'h0, 0, 0, 0, 0, '0, "R2 reserve");
    step(1, 1, 12'h05C, 4'h0, 0, 1, 0, 0, '0, "R3 R10 pass same granule");
    step(1, 1, 12'h040, 4'h0, 0, 1, 1, 0, '0, "R4 cleared after store");
    step(1, 0, 12'h100, 4'h0, 0, 0, 0, 0, '0, "R2 first");
    step(1, 0, 12'h200, 4'h0, 0, 0, 0, 0, '0, "R2 replace");
    step(1, 1, 12'h104, 4'h0, 0, 1, 0, 0, '0, "R2 old granule fails");
    step(1, 0, 12'h040, 4'h0, 0, 0, 0, 0, '0, "R3 setup");
    step(1, 1, 12'h840, 4'h0, 0, 1, 0, 0, '0, "R3 top bit differs");
    step(1, 0, 12'h040, 4'h0, 0, 0, 0, 0, '0, "R3 setup");
    step(1, 1, 12'h060, 4'h0, 0, 1, 1, 0, '0, "R3 next granule fails");
    // R5 snoops
    step(1, 0, 12'h300, 4'h0, 0, 0, 0, 0, '0, "R5 reserve");
    step(0, 0, '0, 4'h0, 0, 0, 0, 1, 12'h320, "R5 snoop miss");
    step(1, 1, 12'h31C, 4'h0, 0, 1, 1, 0, '0, "R5 pass after miss");
    step(1, 0, 12'h300, 4'h0, 0, 0, 0, 0, '0, "R5 reserve");
    step(0, 0, '0, 4'h0, 0, 0, 0, 1, 12'h308, "R5 snoop hit");
    step(1, 1, 12'h300, 4'h0, 0, 1, 0, 0, '0, "R5 fail after hit");
    step(1, 0, 12'h300, 4'h0, 0, 0, 0, 0, '0, "R5 reserve");
    step(1, 1, 12'h300, 4'h0, 0, 1, 0, 1, 12'h31F, "R5 snoop same cycle as store");
    step(1, 0, 12'h300, 4'h0, 0, 0, 0, 0, '0, "R5 reserve");
    step(1, 0, 12'h400, 4'h0, 0, 0, 0, 1, 12'h300, "R5 snoop with new reserve");
    step(1, 1, 12'h400, 4'h0, 0, 1, 0, 0, '0, "R5 new reservation kept");
    // R6 / R7 / R8 / R9 faults
    step(1, 0, 12'h500, 4'h0, 0, 0, 0, 0, '0, "R9 setup");
    step(1, 0, 12'h102, 4'h8, 1, 0, 0, 0, '0, "R6 align first");
    step(1, 1, 12'h501, 4'h0, 0, 1, 0, 0, '0, "R6 store misaligned");
    step(1, 0, 12'h100, 4'hB, 1, 0, 0, 0, '0, "R7 write-through over lock");
    step(1, 1, 12'h500, 4'h8, 0, 1, 0, 0, '0, "R7 store write-through");
    step(1, 1, 12'h500, 4'h0, 1, 1, 0, 0, '0, "R8 R9 store locked");
    step(1, 0, 12'h100, 4'hC, 0, 0, 0, 0, '0, "R7 11xx not a fault");
    step(1, 0, 12'h500, 4'h2, 0, 0, 0, 0, '0, "R7 0010 not a fault");
    step(1, 0, 12'h100, 4'h0, 1, 1, 0, 0, '0, "R9 faulting reserve keeps");
    step(1, 1, 12'h500, 4'h0, 0, 1, 1, 0, '0, "R9 reservation survived");
    // R11 / R12
    step(1, 0, 12'h600, 4'h0, 0, 1, 0, 0, '0, "R12 reserve rc set");
    step(1, 1, 12'h610, 4'h0, 0, 0, 1, 0, '0, "R11 store rc clear");
    step(1, 1, 12'h600, 4'h0, 0, 0, 0, 0, '0, "R11 rc clear still cleared");
    idle("R13 idle");
    idle("R13 idle");
    repeat (3) @(posedge clk);
    #2;
    finish_tb();
  end
endmodule